// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobes and address/data drive for a multiplexed external memory bus of an 8-bit controller whose machine cycle lasts twelve oscillator periods. Every machine cycle is split into two six-period slots. In an ordinary cycle each slot can carry one external code fetch: an address-latch pulse that marks the low address byte on the shared port, then a program-read strobe while the port floats to accept the instruction byte. The high address byte is driven on a separate port for the whole slot.

When the core requests a data access for the next machine cycle, that cycle becomes a data cycle. Only the first address-latch pulse is issued, and it carries the data address. The second latch pulse and both program-read strobes are dropped. A single read or write strobe is issued, six periods long, starting three periods after the latch pulse falls. For a write the shared port carries the write data. For a read the port floats and the returned byte is captured at the end of the strobe. The high port carries either the upper data address byte or the contents of its own port latch, depending on the address width selected. A suppression control stops the free-running latch pulses while code runs from internal memory. It has no effect while code is fetched externally.

Top module: `ext_bus_seq`

## Requirements
- R1: A phase counter runs 0..11 from the release of reset and marks machine-cycle boundaries. In a non-data cycle, `ale` is high in phases 0, 1, 6 and 7 when `ext_exec` is 1 or `ale_off` is 0, and low in all other phases.
- R2: In a non-data cycle with `ext_exec`=1, `psen_n` is low in phases 3-5 and 9-11. It stays high at all other times, including every phase while `ext_exec`=0.
- R3: In a data cycle, `ale` is high only in phases 0 and 1, and `psen_n` stays high for all twelve phases.
- R4: In a data cycle, exactly one of `rd_n` (for a read) or `wr_n` (for a write) is low, in phases 5 to 10 inclusive. Both are high in every other phase and in every non-data cycle.
- R5: `bus_oe` is 1 and `bus_out` carries the low address byte in the first three phases of an address slot. For a fetch slot (offsets 0-2) this is bits 7:0 of `fetch_addr` as sampled at the last phase (5 or 11) before the slot. For a data cycle (phases 0-2) it is bits 7:0 of the captured `acc_addr`.
- R6: In a data write, `bus_oe`=1 and `bus_out`=captured `acc_wdata` in phases 3-11. In a data read, `bus_oe`=0 in phases 3-11. In a fetch slot `bus_oe`=0 at offsets 3-5. With `ext_exec`=0, `bus_oe`=0 throughout a non-data cycle.
- R7: `hi_out` equals bits 15:8 of the slot's fetch address in a non-data cycle with `ext_exec`=1. In a data cycle with `acc_wide`=1 it equals bits 15:8 of `acc_addr`. In all other cases, including reset, it equals `hi_latch`.
- R8: With `ale_off`=1 and `ext_exec`=0, `ale` stays low through non-data cycles but still pulses in phases 0-1 of a data cycle. With `ext_exec`=1, `ale_off` has no effect.
- R9: In a data read, `bus_in` is captured at phase 10. `rd_data` shows that byte and `rd_valid` is 1 in phase 11. `rd_valid` is 0 at all other times.
- R10: The access inputs (`acc_req`, `acc_wr`, `acc_wide`, `acc_addr`, `acc_wdata`) are sampled only at the clock edge that ends phase 11, and changing them in phases 0-10 has no effect on any output. During reset `ale`=0, `psen_n`=`rd_n`=`wr_n`=1, `bus_oe`=0 and `rd_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_exec | input | 1 | Code runs from external memory |
| ale_off | input | 1 | Suppress free-running address latch pulses |
| fetch_addr | input | AW | Next code fetch address |
| acc_req | input | 1 | Data access requested for next machine cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| acc_addr | input | AW | Data address |
| acc_wdata | input | DW | Write data |
| hi_latch | input | AW-DW | High port latch contents |
| bus_in | input | DW | Shared port input value |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Program read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| bus_out | output | DW | Shared port output value |
| bus_oe | output | 1 | Shared port drive enable |
| hi_out | output | AW-DW | High port output |
| rd_data | output | DW | Captured read byte |
| rd_valid | output | 1 | Read byte valid |

## Verification
The bench sweeps all four combinations of external execution and latch suppression across idle, 8-bit and 16-bit read and write cycles, and compares every output in every phase. A design that issued the second latch pulse or any program strobe in a data cycle would show extra pulses in phases 6-11. A design that started or ended a data strobe one period off would fail at phase 4, 5, 10 or 11. A design that let suppression act during external execution would lose the pulses that the fetches need. Mid-cycle changes on the access inputs show whether the request is sampled anywhere but the phase-11 edge. A read that left the port driven, or an 8-bit access that put address bits on the high port, would also be caught.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_exec,
  input  logic             ale_off,
  input  logic [AW-1:0]    fetch_addr,
  input  logic             acc_req,
  input  logic             acc_wr,
  input  logic             acc_wide,
  input  logic [AW-1:0]    acc_addr,
  input  logic [DW-1:0]    acc_wdata,
  input  logic [AW-DW-1:0] hi_latch,
  input  logic [DW-1:0]    bus_in,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    bus_out,
  output logic             bus_oe,
  output logic [AW-DW-1:0] hi_out,
  output logic [DW-1:0]    rd_data,
  output logic             rd_valid
);
  localparam int SLOT = 6;
  localparam int MC = 2 * SLOT;
  localparam logic [3:0] LAST = 4'(MC - 1);
  localparam logic [3:0] HALF = 4'(SLOT);
  localparam logic [3:0] STB_ON = 4'(SLOT - 1);
  localparam logic [3:0] STB_OFF = 4'(MC - 2);

  logic [3:0]    ph, off;
  logic          dcyc, dwr, dwide;
  logic [AW-1:0] da, fa;
  logic [DW-1:0] dwd;
  logic          addr_ph, strobe_ph, rd_cyc;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph <= '0; dcyc <= 1'b0; dwr <= 1'b0; dwide <= 1'b0;
      da <= '0; dwd <= '0; fa <= '0; rd_data <= '0;
    end else begin
      ph <= (ph == LAST) ? '0 : ph + 4'd1;
      if (ph == LAST || ph == HALF - 4'd1) fa <= fetch_addr;
      if (ph == LAST) begin
        dcyc <= acc_req; dwr <= acc_wr; dwide <= acc_wide;
        da <= acc_addr; dwd <= acc_wdata;
      end
      if (rd_cyc && ph == STB_OFF) rd_data <= bus_in;
    end
  end

  assign off       = (ph >= HALF) ? ph - HALF : ph;
  assign addr_ph   = off < 4'd3;
  assign strobe_ph = ph >= STB_ON && ph <= STB_OFF;
  assign rd_cyc    = dcyc && !dwr;

  assign ale = !rst && (dcyc ? (ph < 4'd2) : (off < 4'd2 && (ext_exec || !ale_off)));
  assign psen_n = rst || dcyc || !ext_exec || addr_ph;
  assign rd_n = !(!rst && rd_cyc && strobe_ph);
  assign wr_n = !(!rst && dcyc && dwr && strobe_ph);
  assign bus_oe = !rst && (dcyc ? (ph < 4'd3 || dwr) : (ext_exec && addr_ph));
  assign bus_out = dcyc ? ((ph < 4'd3) ? da[DW-1:0] : dwd) : fa[DW-1:0];
  assign hi_out = rst ? hi_latch
                : dcyc ? (dwide ? da[AW-1:DW] : hi_latch)
                : (ext_exec ? fa[AW-1:DW] : hi_latch);
  assign rd_valid = !rst && rd_cyc && ph == LAST;
endmodule

module ext_bus_seq_chk (
  input logic clk,
  input logic rst,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic bus_oe
);
  a_r4_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));
  a_r3_no_psen_in_access: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> psen_n);
  a_r4_gap_after_ale: assert property (@(posedge clk) disable iff (rst)
    $fell(rd_n) |-> (!ale && !$past(ale) && !$past(ale, 2)));
  a_r6_read_floats: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !bus_oe);
  a_r1_ale_two_wide: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(ale)) |=> !ale);
  a_r5_addr_before_psen: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n) |-> $past(bus_oe));
endmodule

bind ext_bus_seq ext_bus_seq_chk u_chk (
  .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe)
);

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, ext_exec, ale_off, acc_req, acc_wr, acc_wide;
  logic [15:0] fetch_addr, acc_addr;
  logic [7:0] acc_wdata, hi_latch, bus_in;
  logic ale, psen_n, rd_n, wr_n, bus_oe, rd_valid;
  logic [7:0] bus_out, hi_out, rd_data;

  ext_bus_seq u_dut (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", what, act, exp, $time);
    end
  endtask

  logic c_data, c_wr, c_wide, c_ext, c_aleoff;
  logic [15:0] c_addr, slot_fa, fa_next;
  logic [7:0] c_wd, c_hi, c_pin;

  task automatic check_phase(input int ph);
    int off = ph % 6;
    logic e_ale, e_psen, e_rd, e_wr, e_oe;
    logic [7:0] e_out, e_hi;
    if (c_data) begin
      e_ale = ph < 2;
      e_psen = 1'b1;
      e_rd = !(!c_wr && ph >= 5 && ph <= 10);
      e_wr = !(c_wr && ph >= 5 && ph <= 10);
      e_oe = ph < 3 || c_wr;
      e_out = (ph < 3) ? c_addr[7:0] : c_wd;
      e_hi = c_wide ? c_addr[15:8] : c_hi;
    end else begin
      e_ale = off < 2 && (c_ext || !c_aleoff);
      e_psen = !(c_ext && off >= 3);
      e_rd = 1'b1; e_wr = 1'b1;
      e_oe = c_ext && off < 3;
      e_out = slot_fa[7:0];
      e_hi = c_ext ? slot_fa[15:8] : c_hi;
    end
    chk(16'(ale), 16'(e_ale), $sformatf("R1/R3/R8 ale ph%0d", ph));
    chk(16'(psen_n), 16'(e_psen), $sformatf("R2/R3 psen_n ph%0d", ph));
    chk({15'd0, rd_n}, {15'd0, e_rd}, $sformatf("R4 rd_n ph%0d", ph));
    chk({15'd0, wr_n}, {15'd0, e_wr}, $sformatf("R4 wr_n ph%0d", ph));
    chk(16'(bus_oe), 16'(e_oe), $sformatf("R5/R6 bus_oe ph%0d", ph));
    if (e_oe) chk(16'(bus_out), 16'(e_out), $sformatf("R5/R6 bus_out ph%0d", ph));
    chk(16'(hi_out), 16'(e_hi), $sformatf("R7 hi_out ph%0d", ph));
    chk(16'(rd_valid), 16'(c_data && !c_wr && ph == 11), $sformatf("R9 rd_valid ph%0d", ph));
    if (c_data && !c_wr && ph == 11) chk(16'(rd_data), 16'(c_pin), "R9 rd_data");
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    rst = 1; ext_exec = 0; ale_off = 0; acc_req = 0; acc_wr = 0; acc_wide = 0;
    fetch_addr = 0; acc_addr = 0; acc_wdata = 0; hi_latch = 8'h3c; bus_in = 8'h00;
    repeat (3) @(negedge clk);
    #1;
    chk(16'(ale), 16'd0, "R10 reset ale");
    chk(16'(psen_n), 16'd1, "R10 reset psen_n");
    chk({15'd0, rd_n & wr_n}, 16'd1, "R10 reset strobes");
    chk(16'(bus_oe), 16'd0, "R10 reset bus_oe");
    chk(16'(rd_valid), 16'd0, "R10 reset rd_valid");
    chk(16'(hi_out), 16'h3c, "R7 reset hi_out");
    @(negedge clk);
    rst = 0;
    c_data = 0; c_wr = 0; c_wide = 0; c_ext = 0; c_aleoff = 0;
    c_addr = 0; c_wd = 0; c_hi = 8'h3c; c_pin = 0; slot_fa = 0; fa_next = 0;
    for (int n = 0; n < 41; n++) begin
      for (int ph = 0; ph < 12; ph++) begin
        #1;
        if (ph == 6) slot_fa = fa_next;
        check_phase(ph);
        if (ph == 0) begin
          // R10: mid-cycle garbage on access inputs must be ignored
          acc_req = 1; acc_wr = ~c_wr; acc_wide = ~c_wide;
          acc_addr = 16'hdead ^ 16'(n); acc_wdata = 8'hee;
        end
        if (ph == 5) begin
          fa_next = 16'(n * 16'h0321 + 16'h4a07);
          fetch_addr = fa_next;
        end
        if (ph == 11) begin
          int m = n + 1;
          int k = m % 5;
          logic [1:0] cfg = 2'((m / 5) % 4);
          c_data = k != 0;
          c_wr = k >= 3;
          c_wide = k == 2 || k == 4;
          c_addr = 16'(m * 16'h0913 + 16'h1234);
          c_wd = 8'(m * 8'h1d + 3);
          c_hi = 8'(m * 8'h11) ^ 8'h5a;
          c_pin = 8'(m * 7 + 1);
          c_ext = cfg[0];
          c_aleoff = cfg[1];
          acc_req = c_data; acc_wr = c_wr; acc_wide = c_wide;
          acc_addr = c_addr; acc_wdata = c_wd;
          hi_latch = c_hi; bus_in = c_pin;
          ext_exec = c_ext; ale_off = c_aleoff;
          fa_next = 16'(m * 16'h0b17 + 16'h0102);
          fetch_addr = fa_next;
          slot_fa = fa_next;
        end
        @(negedge clk);
      end
    end
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule